// File: doc/BRIEF.md
# ADC Sample Integrator

This block sits behind a 12-bit converter whose samples arrive as 16-bit words, one word per clock at most, each marked by a valid strobe. The 12-bit code occupies the upper part of the word (bits 15..4) and the four low bits are padding. The block recovers the code, widens it to a signed accumulator value, and sums those values over an integration window that is opened and closed by control pulses.

A static format input selects how the code is read. It can be read as a two's-complement number, or as an offset-binary number in which code 0 is the most negative input and code 4095 the most positive. Offset-binary codes are re-centred on zero before widening, so both formats feed the same signed sum. The sum saturates at the accumulator limits instead of wrapping. When a window closes, the block presents the final total together with a window overflow flag and a one-cycle done strobe.

The widened value of every sample also appears on its own output one cycle after the input is taken. The accumulator width is a parameter, with a default of 32 bits.

Top module: `adc_window_integrator`

## Requirements
- R1: Bits 3..0 of `in_word` have no effect on any output; only bits 15..4 form the 12-bit code.
- R2: With `fmt_offset` = 0 the code is a two's-complement number, sign-extended to ACC_W bits (0xFFF0 gives -1, 0x0010 gives +1, 0x8000 gives -2048, 0x7FF0 gives +2047). It appears on `sample_out`, with `sample_valid` high, one clock after `in_valid` is taken.
- R3: With `fmt_offset` = 1 the code is offset binary. Code bit 11 (word bit 15) is inverted before sign extension, so code 0 gives -2048, code 2048 gives 0 and code 4095 gives +2047.
- R4: A `win_start` pulse opens a window and discards any earlier running total. The sample taken in the same cycle, if valid, is the first term of the window.
- R5: Only samples with `in_valid` high that fall inside an open window are added. Samples outside a window, and a `win_end` with no open window, leave the sum unchanged and produce no done strobe.
- R6: A `win_end` pulse closes the window, and the sample in that cycle, if valid, is the last term. Two clocks after that input is taken, `sum_out` shows the total and `sum_done` is high for exactly one cycle. `sum_out` holds its value until the next window closes.
- R7: A window may start in the cycle right after another ends. No sample is lost and neither total affects the other.
- R8: The running sum saturates at the signed ACC_W limits. `sum_ovf` reports whether saturation occurred anywhere in the window just closed, and the flag is cleared when the next window starts.
- R9: The block accepts a valid sample on every clock. A window of back-to-back samples sums every one of them.
- R10: After reset, `sample_valid`, `sum_done` and `sum_ovf` are 0 and `sum_out` is 0.
- R11: `win_start` and `win_end` in the same cycle form a window of exactly that cycle's sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_offset | input | 1 | Code format: 0 two's complement, 1 offset binary |
| in_valid | input | 1 | Input word holds a sample |
| in_word | input | 16 | Left-justified 12-bit code with 4 padding bits |
| win_start | input | 1 | Open a window starting with this cycle's sample |
| win_end | input | 1 | Close the window after this cycle's sample |
| sample_out | output | ACC_W | Widened signed sample |
| sample_valid | output | 1 | `sample_out` holds a new sample |
| sum_out | output | ACC_W | Total of the last closed window |
| sum_done | output | 1 | One-cycle strobe: a new total is on `sum_out` |
| sum_ovf | output | 1 | The last closed window saturated |

## Verification
Saturation is the hardest case to reach. At 32 bits it needs about a million full-scale samples, far more than a short run allows. The bench therefore drives a second instance, with a 16-bit accumulator, from the same stimulus: twenty full-scale samples push that instance past both limits, while the 32-bit instance must show the exact unsaturated total. Full coverage of the conversion comes from sweeping all 4096 codes in both formats with varying padding bits. The hand-off from one window to the next is checked with a start pulse in the cycle that directly follows an end pulse.

// File: rtl/adc_integ_pkg.sv
package adc_integ_pkg;

    localparam int WORD_W    = 16;
    localparam int CODE_W    = 12;
    localparam int PAD_W     = WORD_W - CODE_W;
    localparam int ACC_W_DEF = 32;

    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } code_fmt_e;

    // Control bits that travel with each sample through the pipeline.
    typedef struct packed {
        logic valid;
        logic start;
        logic stop;
    } samp_ctl_t;

    // Upper CODE_W bits of the word; padding bits are dropped here.
    function automatic logic [CODE_W-1:0] take_code(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: CODE_W];
    endfunction

    // Map a code to a two's-complement value centred on zero.
    function automatic logic [CODE_W-1:0] center_code(input logic [CODE_W-1:0] c,
                                                      input code_fmt_e fmt);
        logic [CODE_W-1:0] r;
        r = c;
        if (fmt == FMT_OFFSET) begin
            r[CODE_W-1] = ~c[CODE_W-1];
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_code_align.sv
module adc_code_align
    import adc_integ_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  code_fmt_e         fmt,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              win_start,
    input  logic              win_end,
    output logic [ACC_W-1:0]  out_value,
    output samp_ctl_t         out_ctl
);

    localparam int EXT_W = ACC_W - CODE_W;

    logic [CODE_W-1:0] raw_code;
    logic [CODE_W-1:0] cen_code;
    logic [ACC_W-1:0]  wide_value;

    always_comb begin
        raw_code   = take_code(in_word);
        cen_code   = center_code(raw_code, fmt);
        wide_value = {{EXT_W{cen_code[CODE_W-1]}}, cen_code};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_value <= '0;
            out_ctl   <= '0;
        end else begin
            out_value     <= wide_value;
            out_ctl.valid <= in_valid;
            out_ctl.start <= win_start;
            out_ctl.stop  <= win_end;
        end
    end

    // R2: every widened sample is a proper sign extension of a 12-bit value
    assert_sign_ext_R2: assert property (@(posedge clk) disable iff (rst)
        out_ctl.valid |-> (out_value[ACC_W-1:CODE_W-1] == '0 ||
                           out_value[ACC_W-1:CODE_W-1] == '1));

    // R9: one stage of latency, one sample per clock
    assert_one_per_clock_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_ctl.valid == $past(in_valid)));

endmodule

// File: rtl/adc_sat_add.sv
module adc_sat_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         clipped
);

    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W:0] wide;

    always_comb begin
        wide    = {a[W-1], a} + {b[W-1], b};
        clipped = wide[W] ^ wide[W-1];
        if (!clipped) begin
            sum = wide[W-1:0];
        end else if (wide[W]) begin
            sum = NEG_LIM;
        end else begin
            sum = POS_LIM;
        end
    end

endmodule

// File: rtl/adc_window_accum.sv
module adc_window_accum
    import adc_integ_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] in_value,
    input  samp_ctl_t        in_ctl,
    output logic [ACC_W-1:0] sum_out,
    output logic             sum_ovf,
    output logic             sum_done
);

    localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

    logic             open_q;
    logic [ACC_W-1:0] acc_q;
    logic             ovf_q;

    logic             in_win;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] addend;
    logic             ovf_base;
    logic [ACC_W-1:0] acc_n;
    logic             clip;
    logic             ovf_n;

    always_comb begin
        in_win   = in_ctl.start | open_q;
        base     = in_ctl.start ? '0 : acc_q;
        ovf_base = in_ctl.start ? 1'b0 : ovf_q;
        addend   = (in_ctl.valid && in_win) ? in_value : '0;
        ovf_n    = ovf_base | clip;
    end

    adc_sat_add #(.W(ACC_W)) u_add (
        .a       (base),
        .b       (addend),
        .sum     (acc_n),
        .clipped (clip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            acc_q    <= '0;
            ovf_q    <= 1'b0;
            sum_out  <= '0;
            sum_ovf  <= 1'b0;
            sum_done <= 1'b0;
        end else begin
            sum_done <= 1'b0;
            if (in_win) begin
                acc_q  <= acc_n;
                ovf_q  <= ovf_n;
                open_q <= ~in_ctl.stop;
                if (in_ctl.stop) begin
                    sum_out  <= acc_n;
                    sum_ovf  <= ovf_n;
                    sum_done <= 1'b1;
                end
            end
        end
    end

    // R6: a done strobe only follows a window end carried by the pipeline
    assert_done_after_end_R6: assert property (@(posedge clk) disable iff (rst)
        sum_done |-> $past(in_ctl.stop));

    // R4: a start with no sample leaves an empty running total
    assert_start_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (in_ctl.start && !in_ctl.valid) |=> (acc_q == '0));

    // R5: outside a window the running total does not move
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !in_win |=> $stable(acc_q));

    // R8: a clipped addition lands on one of the limits
    assert_clip_limit_R8: assert property (@(posedge clk) disable iff (rst)
        (in_win && clip) |=> (acc_q == POS_LIM || acc_q == NEG_LIM));

    // R8: the overflow flag stays set for the rest of the window
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (open_q && ovf_q && !in_ctl.start) |=> ovf_q);

endmodule

// File: rtl/adc_window_integrator.sv
module adc_window_integrator
    import adc_integ_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fmt_offset,
    input  logic             in_valid,
    input  logic [15:0]      in_word,
    input  logic             win_start,
    input  logic             win_end,
    output logic [ACC_W-1:0] sample_out,
    output logic             sample_valid,
    output logic [ACC_W-1:0] sum_out,
    output logic             sum_done,
    output logic             sum_ovf
);

    code_fmt_e        fmt_sel;
    logic [ACC_W-1:0] s1_value;
    samp_ctl_t        s1_ctl;

    assign fmt_sel = code_fmt_e'(fmt_offset);

    adc_code_align #(.ACC_W(ACC_W)) u_align (
        .clk       (clk),
        .rst       (rst),
        .fmt       (fmt_sel),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .win_start (win_start),
        .win_end   (win_end),
        .out_value (s1_value),
        .out_ctl   (s1_ctl)
    );

    adc_window_accum #(.ACC_W(ACC_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .in_value (s1_value),
        .in_ctl   (s1_ctl),
        .sum_out  (sum_out),
        .sum_ovf  (sum_ovf),
        .sum_done (sum_done)
    );

    assign sample_out   = s1_value;
    assign sample_valid = s1_ctl.valid;

    // R10: nothing is reported in the cycle after reset
    assert_quiet_after_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (!sum_done && !sample_valid));

endmodule

// File: tb/adc_window_integrator_test.sv
module adc_window_integrator_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_offset = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        win_start = 1'b0;
    logic        win_end = 1'b0;

    logic [31:0] sample_out;
    logic        sample_valid;
    logic [31:0] sum_out;
    logic        sum_done;
    logic        sum_ovf;

    logic [15:0] n_sample_out;
    logic        n_sample_valid;
    logic [15:0] n_sum_out;
    logic        n_sum_done;
    logic        n_sum_ovf;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_window_integrator uut (
        .clk(clk), .rst(rst), .fmt_offset(fmt_offset), .in_valid(in_valid),
        .in_word(in_word), .win_start(win_start), .win_end(win_end),
        .sample_out(sample_out), .sample_valid(sample_valid),
        .sum_out(sum_out), .sum_done(sum_done), .sum_ovf(sum_ovf)
    );

    adc_window_integrator #(.ACC_W(16)) uut_sat (
        .clk(clk), .rst(rst), .fmt_offset(fmt_offset), .in_valid(in_valid),
        .in_word(in_word), .win_start(win_start), .win_end(win_end),
        .sample_out(n_sample_out), .sample_valid(n_sample_valid),
        .sum_out(n_sum_out), .sum_done(n_sum_done), .sum_ovf(n_sum_ovf)
    );

    // {fmt, word, expected widened value}
    localparam logic [48:0] VEC [12] = '{
        {1'b0, 16'hFFF0, 32'hFFFF_FFFF},
        {1'b0, 16'h0010, 32'h0000_0001},
        {1'b0, 16'h7FF0, 32'h0000_07FF},
        {1'b0, 16'h8000, 32'hFFFF_F800},
        {1'b0, 16'h001F, 32'h0000_0001},
        {1'b0, 16'h000F, 32'h0000_0000},
        {1'b1, 16'h0000, 32'hFFFF_F800},
        {1'b1, 16'hFFFF, 32'h0000_07FF},
        {1'b1, 16'h8000, 32'h0000_0000},
        {1'b1, 16'h7FF0, 32'hFFFF_FFFF},
        {1'b1, 16'h800F, 32'h0000_0000},
        {1'b1, 16'h8010, 32'h0000_0001}
    };

    // captured window results
    logic [31:0] res_w [16];
    logic        res_w_ovf [16];
    int          n_w = 0;
    logic [31:0] res_n [16];
    logic        res_n_ovf [16];
    int          n_n = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (sum_done) begin
                if (n_w < 16) begin
                    res_w[n_w]     = sum_out;
                    res_w_ovf[n_w] = sum_ovf;
                end
                n_w = n_w + 1;
            end
            if (n_sum_done) begin
                if (n_n < 16) begin
                    res_n[n_n]     = {{16{n_sum_out[15]}}, n_sum_out};
                    res_n_ovf[n_n] = n_sum_ovf;
                end
                n_n = n_n + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, $signed(got), $signed(exp));
        end
    endtask

    task automatic put(input logic v, input logic [15:0] w, input logic s, input logic e);
        @(negedge clk);
        in_valid  = v;
        in_word   = w;
        win_start = s;
        win_end   = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 16'h0000, 1'b0, 1'b0);
    endtask

    function automatic logic [15:0] wd(input int v);
        logic [31:0] t;
        t = 32'(v);
        return {t[11:0], 4'h0};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 sample_valid", 32'(sample_valid), 32'd0);
        check("R10 sum_done", 32'(sum_done), 32'd0);
        check("R10 sum_ovf", 32'(sum_ovf), 32'd0);
        check("R10 sum_out", sum_out, 32'd0);
        rst = 1'b0;
        idle(2);

        // R1 R2 R3: vector table
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            fmt_offset = VEC[i][48];
            in_word    = VEC[i][47:32];
            in_valid   = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check("R2 sample_valid", 32'(sample_valid), 32'd1);
            check(VEC[i][48] ? "R3 table" : "R2 R1 table", sample_out, VEC[i][31:0]);
        end

        // R2 R1: sweep every two's-complement code with varying padding
        for (int v = -2048; v < 2048; v++) begin
            logic [31:0] t;
            t = 32'(v);
            @(negedge clk);
            fmt_offset = 1'b0;
            in_word    = {t[11:0], t[3:0] ^ 4'hA};
            in_valid   = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check("R2 sweep", sample_out, t);
        end
        // R3: sweep every offset-binary code
        for (int v = -2048; v < 2048; v++) begin
            logic [31:0] c;
            c = 32'(v + 2048);
            @(negedge clk);
            fmt_offset = 1'b1;
            in_word    = {c[11:0], c[7:4]};
            in_valid   = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check("R3 sweep", sample_out, 32'(v));
        end
        fmt_offset = 1'b0;
        idle(2);

        // R5: samples outside a window and a lone end give no result
        put(1'b1, wd(1000), 1'b0, 1'b0);
        put(1'b1, wd(-7), 1'b0, 1'b0);
        put(1'b1, wd(3), 1'b0, 1'b1);
        idle(4);
        check("R5 no done outside window", 32'(n_w), 32'd0);

        // W0 R11: single-sample window
        put(1'b1, wd(42), 1'b1, 1'b1);
        idle(3);
        // W1 R4 R5: invalid cycle inside window contributes nothing
        put(1'b1, wd(5), 1'b1, 1'b0);
        put(1'b0, wd(100), 1'b0, 1'b0);
        put(1'b1, wd(-3), 1'b0, 1'b0);
        put(1'b1, wd(10), 1'b0, 1'b1);
        // W2 R7: starts the very next cycle
        put(1'b1, wd(7), 1'b1, 1'b0);
        put(1'b1, wd(8), 1'b0, 1'b1);
        idle(3);
        // W3 R9: sample every clock
        for (int k = 1; k <= 100; k++) put(1'b1, wd(k), k == 1, k == 100);
        idle(3);
        // W4 R8: positive saturation on the narrow instance
        for (int k = 0; k < 20; k++) put(1'b1, wd(2047), k == 0, k == 19);
        idle(3);
        // W5 R8 R6: flag cleared, done timing
        put(1'b1, wd(1), 1'b1, 1'b0);
        put(1'b1, wd(1), 1'b0, 1'b1);
        put(1'b0, 16'h0000, 1'b0, 1'b0);
        check("R6 done not early", 32'(sum_done), 32'd0);
        @(negedge clk);
        check("R6 done strobe", 32'(sum_done), 32'd1);
        check("R6 sum on done", sum_out, 32'd2);
        @(negedge clk);
        check("R6 done one cycle", 32'(sum_done), 32'd0);
        check("R6 sum held", sum_out, 32'd2);
        idle(2);
        // W6 R8: negative saturation
        for (int k = 0; k < 20; k++) put(1'b1, wd(-2048), k == 0, k == 19);
        idle(3);
        // W7 R3: window in offset-binary mode
        fmt_offset = 1'b1;
        put(1'b1, 16'h8050, 1'b1, 1'b0);
        put(1'b1, 16'h7FF0, 1'b0, 1'b1);
        idle(4);
        fmt_offset = 1'b0;

        check("R6 window count", 32'(n_w), 32'd8);
        check("R6 window count narrow", 32'(n_n), 32'd8);
        if (n_w >= 8 && n_n >= 8) begin
            check("R11 single", res_w[0], 32'd42);
            check("R4 R5 total", res_w[1], 32'd12);
            check("R7 back-to-back", res_w[2], 32'd15);
            check("R9 every clock", res_w[3], 32'd5050);
            check("R9 every clock narrow", res_n[3], 32'd5050);
            check("R8 wide no clip", res_w[4], 32'd40940);
            check("R8 wide no flag", 32'(res_w_ovf[4]), 32'd0);
            check("R8 narrow clip high", res_n[4], 32'd32767);
            check("R8 narrow flag", 32'(res_n_ovf[4]), 32'd1);
            check("R8 flag cleared", 32'(res_n_ovf[5]), 32'd0);
            check("R8 narrow after clip", res_n[5], 32'd2);
            check("R8 wide negative", res_w[6], 32'(-40960));
            check("R8 narrow clip low", res_n[6], 32'(-32768));
            check("R8 narrow flag low", 32'(res_n_ovf[6]), 32'd1);
            check("R3 offset window", res_w[7], 32'd4);
        end
        finish_run();
    end

endmodule